// File: doc/BRIEF.md
# Variable-Page Translation Buffer with Access Check

This block is a small fully associative translation buffer for 32-bit effective addresses. Each entry carries its own page size, a power of four from 1 KB up to 1 GB. A lookup compares the effective address with every valid entry at once. Only the upper address bits that lie above that entry's page offset take part in the compare. The block then builds the real address and checks the access against the entry's six permission bits.

A lookup is presented for one cycle. The registered result appears one cycle later and holds the following:
- a hit or miss indication;
- a multi-hit flag;
- the real address;
- the entry's nine memory and cache attribute bits;
- a permission fault, split into an instruction-side type and a data-side type.

Entries are loaded through a single write port, one whole entry per cycle. Replacement, table walking and cache handling are done elsewhere.

Top module: `vpage_tlb`

## Requirements
- R1: An entry's size code s (0..10) sets a page of 4^s KB. A lookup hits that entry when effective address bits [31:10+2s] equal the matching bits of the entry's 22-bit page number. The page number stands for address bits [31:10]. Its lower 2s bits are ignored.
- R2: An entry whose size code is 11..15 never hits, whatever its page number.
- R3: An entry whose valid bit is clear never hits. Reset (rst_n low at a clock edge) clears every valid bit. Writing an entry with wr_valid low removes it.
- R4: On a hit, the real address bits [31:10+2s] come from the entry's real page number. Bits [9+2s:0] come from the effective address.
- R5: On a hit, the access is allowed only when its permission bit is set. The permission bit index is 3·user + (0 read, 1 write, 2 execute). This gives bit 0 supervisor read, 1 supervisor write, 2 supervisor execute, 3 user read, 4 user write, 5 user execute. The access kind is 00 read, 01 write, 10 or 11 execute.
- R6: A denied execute access raises res_isi. A denied read or write raises res_dsi. Both raise res_fault, and never both types at once.
- R7: A lookup that matches no entry raises res_miss. It leaves res_hit, res_fault, res_ra and res_attr low.
- R8: When several entries match, res_multi rises and the lowest-indexed matching entry supplies the address, attributes and permissions.
- R9: On a hit, res_attr carries the entry's nine attribute bits unchanged. It is zero on a miss.
- R10: The result of a lookup presented at clock edge k is visible after edge k. A write at edge k is seen by lookups at edge k+1 and later, but not by a lookup at the same edge.
- R11: In a cycle after an edge without a lookup request, res_valid, res_hit, res_miss, res_multi, res_fault, res_isi and res_dsi are all low. res_ra and res_attr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| wr_en | input | 1 | write one entry |
| wr_idx | input | IDX_W | entry number to write |
| wr_valid | input | 1 | valid bit of the written entry |
| wr_size | input | 4 | page size code |
| wr_epn | input | 22 | effective page number (address bits 31:10) |
| wr_rpn | input | 22 | real page number (address bits 31:10) |
| wr_perm | input | 6 | permission bits, layout in R5 |
| wr_attr | input | 9 | memory and cache attribute bits |
| lk_req | input | 1 | lookup request |
| lk_ea | input | 32 | effective address |
| lk_user | input | 1 | 1 user mode, 0 supervisor mode |
| lk_kind | input | 2 | access kind, encoding in R5 |
| res_valid | output | 1 | result present this cycle |
| res_hit | output | 1 | an entry matched |
| res_miss | output | 1 | no entry matched |
| res_multi | output | 1 | more than one entry matched |
| res_ra | output | 32 | real address |
| res_attr | output | 9 | attribute bits of the selected entry |
| res_fault | output | 1 | access denied on a hit |
| res_isi | output | 1 | denied execute access |
| res_dsi | output | 1 | denied read or write access |

## Verification
A corrupted entry field shows up on the first lookup that reaches the entry. A wrong size or page number turns a hit into a miss or the reverse. A wrong real page number bends the real address. A flipped permission bit makes a fault appear or vanish. All of these are visible one cycle after the lookup. A stale valid bit, or a wrong choice among several matching entries, shows up the same way on the next lookup of that address. The bench runs a behavioural reference model beside the design and compares every output on every clock, so such an error is caught in the cycle it first reaches the ports.

// File: rtl/vpt_pkg.sv
// Shared constants, entry type and page-mask helper for the variable-page
// translation buffer. Assumes 32-bit addresses and a 1 KB minimum page.
package vpt_pkg;
    localparam int EA_W     = 32;
    localparam int OFS_MIN  = 10;
    localparam int PN_W     = EA_W - OFS_MIN;
    localparam int SIZE_W   = 4;
    localparam int MAX_SIZE = 10;
    localparam int PERM_W   = 6;
    localparam int ATTR_W   = 9;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_EXEC2 = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic              valid;
        logic [SIZE_W-1:0] size;
        logic [PN_W-1:0]   epn;
        logic [PN_W-1:0]   rpn;
        logic [PERM_W-1:0] perm;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    // Page-number bits that take part in the compare for a given size code.
    function automatic logic [PN_W-1:0] page_mask(input logic [SIZE_W-1:0] size);
        logic [PN_W-1:0] m;
        m = '1;
        for (int b = 0; b < PN_W; b++) begin
            if (b < 2 * int'(size)) m[b] = 1'b0;
        end
        return m;
    endfunction
endpackage

// File: rtl/vpt_entry_store.sv
// Entry storage: one register per entry, written whole through one port.
// Assumes wr_idx is below ENTRIES; reset clears every entry (valid included).
module vpt_entry_store
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_data,
    output tlb_entry_t       table_q [ENTRIES]
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        // Load entry e when it is addressed; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                table_q[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                table_q[e] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/vpt_match.sv
// Parallel compare of one effective address against all entries.
// Each entry compares only the page-number bits its size code keeps;
// invalid entries and reserved size codes never match.
module vpt_match
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_entry_t           table_q [ENTRIES],
    input  logic [EA_W-1:0]      ea,
    output logic [ENTRIES-1:0]   match_vec
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [PN_W-1:0] keep;
        logic            size_ok;
        // Compare the kept page-number bits of entry e.
        always_comb begin
            keep         = page_mask(table_q[e].size);
            size_ok      = (int'(table_q[e].size) <= MAX_SIZE);
            match_vec[e] = table_q[e].valid && size_ok &&
                           (((ea[EA_W-1:OFS_MIN] ^ table_q[e].epn) & keep) == '0);
        end
    end
endmodule

// File: rtl/vpt_prio_sel.sv
// Lowest-index priority pick over the match vector, with a flag for
// more than one match. Assumes ENTRIES >= 2.
module vpt_prio_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any,
    output logic               multi,
    output logic [IDX_W-1:0]   sel_idx
);
    // Scan from the top so the lowest matching index wins; count matches.
    always_comb begin
        int cnt;
        cnt     = 0;
        sel_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) begin
                sel_idx = IDX_W'(e);
                cnt     = cnt + 1;
            end
        end
        any   = (cnt != 0);
        multi = (cnt > 1);
    end
endmodule

// File: rtl/vpt_perm_chk.sv
// Permission check for one access: picks the supervisor or user group of
// three bits (read, write, execute) and the bit for the access kind.
module vpt_perm_chk
    import vpt_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic              user,
    input  acc_kind_e         kind,
    output logic              allow,
    output logic              is_exec
);
    // Select the permission bit for mode and access kind.
    always_comb begin
        logic [2:0] grp;
        grp     = user ? perm[5:3] : perm[2:0];
        is_exec = (kind == ACC_EXEC) || (kind == ACC_EXEC2);
        unique case (kind)
            ACC_READ:  allow = grp[0];
            ACC_WRITE: allow = grp[1];
            default:   allow = grp[2];
        endcase
    end
endmodule

// File: rtl/vpage_tlb.sv
// Variable-page translation buffer top: entry store, parallel match,
// priority pick, real-address merge, permission check, and one register
// stage on the result. Assumes a lookup is a single-cycle request.
module vpage_tlb
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [3:0]        wr_size,
    input  logic [21:0]       wr_epn,
    input  logic [21:0]       wr_rpn,
    input  logic [5:0]        wr_perm,
    input  logic [8:0]        wr_attr,
    input  logic              lk_req,
    input  logic [31:0]       lk_ea,
    input  logic              lk_user,
    input  logic [1:0]        lk_kind,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_multi,
    output logic [31:0]       res_ra,
    output logic [8:0]        res_attr,
    output logic              res_fault,
    output logic              res_isi,
    output logic              res_dsi
);
    tlb_entry_t          wr_data;
    tlb_entry_t          table_q [ENTRIES];
    tlb_entry_t          sel_e;
    logic [ENTRIES-1:0]  match_vec;
    logic                any_hit, multi_hit, allow, is_exec;
    logic [IDX_W-1:0]    sel_idx;
    logic [PN_W-1:0]     keep;
    logic [EA_W-1:0]     ra_c;

    // Pack the write port fields into one entry.
    always_comb begin
        wr_data = '{valid: wr_valid, size: wr_size, epn: wr_epn,
                    rpn: wr_rpn, perm: wr_perm, attr: wr_attr};
    end

    vpt_entry_store #(.ENTRIES(ENTRIES)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .table_q(table_q)
    );

    vpt_match #(.ENTRIES(ENTRIES)) i_match (
        .table_q(table_q), .ea(lk_ea), .match_vec(match_vec)
    );

    vpt_prio_sel #(.ENTRIES(ENTRIES)) i_prio (
        .match_vec(match_vec), .any(any_hit), .multi(multi_hit), .sel_idx(sel_idx)
    );

    // Merge the selected real page number with the in-page offset.
    always_comb begin
        sel_e = table_q[sel_idx];
        keep  = page_mask(sel_e.size);
        ra_c  = {(sel_e.rpn & keep) | (lk_ea[EA_W-1:OFS_MIN] & ~keep),
                 lk_ea[OFS_MIN-1:0]};
    end

    vpt_perm_chk i_perm (
        .perm(sel_e.perm), .user(lk_user), .kind(acc_kind_e'(lk_kind)),
        .allow(allow), .is_exec(is_exec)
    );

    // Register the lookup outcome; everything is zero without a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_multi <= 1'b0;
            res_ra    <= '0;
            res_attr  <= '0;
            res_fault <= 1'b0;
            res_isi   <= 1'b0;
            res_dsi   <= 1'b0;
        end else begin
            res_valid <= lk_req;
            res_hit   <= lk_req && any_hit;
            res_miss  <= lk_req && !any_hit;
            res_multi <= lk_req && multi_hit;
            res_ra    <= (lk_req && any_hit) ? ra_c : '0;
            res_attr  <= (lk_req && any_hit) ? sel_e.attr : '0;
            res_fault <= lk_req && any_hit && !allow;
            res_isi   <= lk_req && any_hit && !allow && is_exec;
            res_dsi   <= lk_req && any_hit && !allow && !is_exec;
        end
    end

    // R7
    miss_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (!res_fault && !res_hit));
    // R6
    fault_one_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_isi ^ res_dsi));
    // R4
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!res_hit || res_ra[9:0] == $past(lk_ea[9:0])));
    // R8
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_multi |-> res_hit);
    // R10
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!res_valid && !res_hit && !res_miss && !res_fault));
endmodule

// File: tb/test_vpage_tlb.sv
`timescale 1ns/1ps
module test_vpage_tlb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_size = '0;
    logic [21:0] wr_epn = '0, wr_rpn = '0;
    logic [5:0]  wr_perm = '0;
    logic [8:0]  wr_attr = '0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        lk_user = 1'b0;
    logic [1:0]  lk_kind = '0;
    logic        res_valid, res_hit, res_miss, res_multi, res_fault, res_isi, res_dsi;
    logic [31:0] res_ra;
    logic [8:0]  res_attr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit          m_valid [N];
    int          m_size  [N];
    logic [21:0] m_epn   [N];
    logic [21:0] m_rpn   [N];
    logic [5:0]  m_perm  [N];
    logic [8:0]  m_attr  [N];

    // expected outputs
    bit e_valid, e_hit, e_miss, e_multi, e_fault, e_isi, e_dsi;
    logic [31:0] e_ra;
    logic [8:0]  e_attr;

    always #10 clk = ~clk;

    vpage_tlb i_vpage_tlb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_size(wr_size), .wr_epn(wr_epn), .wr_rpn(wr_rpn), .wr_perm(wr_perm),
        .wr_attr(wr_attr), .lk_req(lk_req), .lk_ea(lk_ea), .lk_user(lk_user),
        .lk_kind(lk_kind), .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_multi(res_multi), .res_ra(res_ra), .res_attr(res_attr), .res_fault(res_fault),
        .res_isi(res_isi), .res_dsi(res_dsi)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", what, got, exp, $time);
        end
    endtask

    // Behavioural prediction of the result for the current inputs.
    task automatic predict();
        int cnt = 0;
        int first = -1;
        int sh;
        logic [31:0] low;
        e_valid = 0; e_hit = 0; e_miss = 0; e_multi = 0;
        e_fault = 0; e_isi = 0; e_dsi = 0; e_ra = '0; e_attr = '0;
        if (!rst_n || !lk_req) return;
        e_valid = 1;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && m_size[i] <= 10) begin
                sh = 10 + 2 * m_size[i];
                if ((lk_ea >> sh) == ({m_epn[i], 10'b0} >> sh)) begin
                    if (first < 0) first = i;
                    cnt++;
                end
            end
        end
        if (first < 0) begin
            e_miss = 1;
            return;
        end
        e_hit = 1;
        e_multi = (cnt > 1);
        sh = 10 + 2 * m_size[first];
        low = (32'h1 << sh) - 32'h1;
        e_ra = ({m_rpn[first], 10'b0} & ~low) | (lk_ea & low);
        e_attr = m_attr[first];
        begin
            int bitn = (lk_user ? 3 : 0) + (lk_kind[1] ? 2 : (lk_kind[0] ? 1 : 0));
            if (!m_perm[first][bitn]) begin
                e_fault = 1;
                e_isi = lk_kind[1];
                e_dsi = !lk_kind[1];
            end
        end
    endtask

    // One clock: predict, update model at the edge, compare at the falling edge.
    task automatic step(input string tag);
        predict();
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else if (wr_en) begin
            m_valid[wr_idx] = wr_valid; m_size[wr_idx] = int'(wr_size);
            m_epn[wr_idx] = wr_epn; m_rpn[wr_idx] = wr_rpn;
            m_perm[wr_idx] = wr_perm; m_attr[wr_idx] = wr_attr;
        end
        @(negedge clk);
        chk({tag, " R11 valid"}, 32'(res_valid), 32'(e_valid));
        chk({tag, " R1 hit"},    32'(res_hit),   32'(e_hit));
        chk({tag, " R7 miss"},   32'(res_miss),  32'(e_miss));
        chk({tag, " R8 multi"},  32'(res_multi), 32'(e_multi));
        chk({tag, " R4 ra"},     res_ra,         e_ra);
        chk({tag, " R9 attr"},   32'(res_attr),  32'(e_attr));
        chk({tag, " R5 fault"},  32'(res_fault), 32'(e_fault));
        chk({tag, " R6 isi"},    32'(res_isi),   32'(e_isi));
        chk({tag, " R6 dsi"},    32'(res_dsi),   32'(e_dsi));
        wr_en = 0;
        lk_req = 0;
    endtask

    task automatic put(input int idx, input bit v, input int sz, input logic [21:0] epn,
                       input logic [21:0] rpn, input logic [5:0] perm, input logic [8:0] attr);
        wr_en = 1; wr_idx = 3'(idx); wr_valid = v; wr_size = 4'(sz);
        wr_epn = epn; wr_rpn = rpn; wr_perm = perm; wr_attr = attr;
    endtask

    task automatic look(input logic [31:0] ea, input bit user, input logic [1:0] kind);
        lk_req = 1; lk_ea = ea; lk_user = user; lk_kind = kind;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_size[i] = 0; m_epn[i] = '0;
            m_rpn[i] = '0; m_perm[i] = '0; m_attr[i] = '0;
        end
        @(negedge clk);
        rst_n = 0;
        step("RST");
        step("RST");
        rst_n = 1;
        // R3: empty after reset
        look(32'h0000_0400, 0, 2'b00); step("R3");
        // R10: write and lookup on the same edge, then the next edge
        put(0, 1, 0, 22'h000001, 22'h12345, 6'h3f, 9'h1a5);
        look(32'h0000_0404, 0, 2'b00); step("R10");
        look(32'h0000_07ff, 0, 2'b00); step("R10");
        look(32'h0000_0800, 0, 2'b00); step("R1");
        // R1/R4: 1 MB page (size 5) and 1 GB page (size 10)
        put(1, 1, 5, 22'h0A0000 | 22'h00155, 22'h1C0000, 6'h3f, 9'h0f0); step("R1");
        look(32'h280F_1234, 1, 2'b01); step("R4");
        look(32'h2810_0000, 1, 2'b01); step("R1");
        put(2, 1, 10, 22'h300000, 22'h100000, 6'h3f, 9'h001); step("R1");
        look(32'hC123_4567, 0, 2'b10); step("R4");
        look(32'h8123_4567, 0, 2'b10); step("R1");
        // R2: reserved size codes never hit
        put(3, 1, 11, 22'h200000, 22'h0, 6'h3f, 9'h0); step("R2");
        put(4, 1, 15, 22'h200000, 22'h0, 6'h3f, 9'h0); step("R2");
        look(32'h8000_0000, 0, 2'b00); step("R2");
        look(32'h8000_0000, 1, 2'b10); step("R2");
        // R5/R6: each single permission bit against every mode and kind
        for (int p = 0; p < 6; p++) begin
            put(5, 1, 2, 22'h040000, 22'h050000, 6'(1 << p), 9'(p)); step("R5");
            for (int u = 0; u < 2; u++)
                for (int k = 0; k < 4; k++) begin
                    look(32'h1000_2abc, u[0], k[1:0]); step("R6");
                end
        end
        // R8: small page inside a large one, lower index wins
        put(6, 1, 1, 22'h300040, 22'h011111, 6'h00, 9'h155); step("R8");
        look(32'hC001_0123, 0, 2'b00); step("R8");
        put(7, 1, 0, 22'h300040, 22'h022222, 6'h3f, 9'h0aa); step("R8");
        look(32'hC001_0010, 1, 2'b01); step("R8");
        // R3: invalidate entry 2, lookup falls to entry 6 or misses
        put(2, 0, 10, 22'h300000, 22'h100000, 6'h3f, 9'h001); step("R3");
        look(32'hC001_0010, 0, 2'b00); step("R3");
        look(32'hC123_4567, 0, 2'b00); step("R3");
        // R11: idle cycles
        step("R11");
        step("R11");
        // Random mix of writes and lookups
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(3) == 0) begin
                logic [21:0] ep;
                ep = 22'($urandom);
                ep[21:18] = 4'($urandom_range(3));
                put($urandom_range(N - 1), ($urandom_range(7) != 0), $urandom_range(12),
                    ep, 22'($urandom), 6'($urandom), 9'($urandom));
            end
            if ($urandom_range(4) != 0) begin
                logic [31:0] a;
                a = $urandom;
                if ($urandom_range(1) == 1) begin
                    int j = $urandom_range(N - 1);
                    a[31:10] = m_epn[j] ^ 22'(1 << $urandom_range(21));
                    if ($urandom_range(1) == 1) a[31:10] = m_epn[j];
                end else begin
                    a[31:28] = 4'($urandom_range(3));
                end
                look(a, 1'($urandom), 2'($urandom));
            end
            step("RND");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule